// File: doc/BRIEF.md
# Pipelined Serial/Parallel Multiplier

This block forms the product of two unsigned operands that are both presented on parallel ports. One operand (the serial operand) is captured in an internal parallel-in serial-out register and is fed, least significant bit first, into a row of multiply cells. The other operand (the parallel operand) is captured in a holding register at the same moment. Each cell gates one bit of the parallel operand with the current serial bit and adds the result into a carry-save running sum. Every cell keeps its own sum and carry flip-flops, so no carry ripples through more than one full adder per clock.

A single mode line chooses between loading (low) and shifting (high), and a clock enable gates every register in the block. One enabled load cycle captures both operands and clears the cell row. It is followed by 2W enabled shift cycles, and each of those places one product bit on the serial output, least significant first, together with a valid strobe. The complete 2W-bit product of two W-bit operands therefore needs 2W shift cycles.

Top module: `serpar_mult`

## Requirements
- R1: While reset is asserted and after it is released, `prod_bit` and `prod_vld` are 0 until the first enabled shift that follows an enabled load.
- R2: An edge with `clk_en`=1 and `shift_mode`=0 captures `opnd_a` and `opnd_b`, clears all partial sums and carries, and leaves `prod_vld`=0 and `prod_bit`=0 after that edge.
- R3: After a load, the k-th enabled edge with `shift_mode`=1 (k = 1 … 2W) presents bit k-1 of the unsigned product `opnd_a * opnd_b` on `prod_bit` with `prod_vld`=1. The stream is least significant bit first.
- R4: Enabled shift edges beyond the 2W-th, and shift edges with no load since reset, give `prod_vld`=0 and `prod_bit`=0.
- R5: An edge with `clk_en`=0 changes no register. `prod_bit` and `prod_vld` hold, and the stream continues afterwards without losing or repeating a bit.
- R6: A load in the middle of a stream abandons it, and the new stream is the exact product of the new operands, with no residue of the earlier one.
- R7: With W=4, the operands 0011 and 1010 give the 8-bit stream 00011110 (value 30), and every 4-bit operand pair gives its exact product.
- R8: Changes on `opnd_a` and `opnd_b` between the load and the end of the stream do not alter the product stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Enables every register update when high |
| shift_mode | input | 1 | 0 = load operands, 1 = shift one step |
| opnd_a | input | W | Parallel operand, captured on load |
| opnd_b | input | W | Serial operand, captured on load and shifted out LSB first |
| prod_bit | output | 1 | Serial product bit, LSB first |
| prod_vld | output | 1 | High while `prod_bit` carries a product bit |

## Verification
If a sum or carry flip-flop holds a wrong value, the error reaches `prod_bit` in the bit position of that cell's column, so it shows as a wrong product bit within at most W further shifts. A carry left over from an earlier product only shows when a reload happens mid-stream, so streams are abandoned at random points and the new product is compared in full. Sequencer faults show as a valid strobe of the wrong length. Faults in the clock-enable gating show when a held output bit changes during a stall.

// File: rtl/serpar_pkg.sv
package serpar_pkg;

    typedef struct packed {
        logic sum;
        logic carry;
    } cell_state_t;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_mode_t;

    function automatic logic [1:0] fa3(input logic x, input logic y, input logic z);
        logic s;
        logic c;
        s = x ^ y ^ z;
        c = (x & y) | (x & z) | (y & z);
        return {c, s};
    endfunction

endpackage

// File: rtl/serpar_serializer.sv
module serpar_serializer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clk_en,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic         bit_o
);
    typedef struct packed {
        logic [W-1:0] word;
    } ser_state_t;

    ser_state_t st_d;
    ser_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (clk_en) begin
            if (load) begin
                st_d.word = din;
            end else begin
                st_d.word = {1'b0, st_q.word[W-1:1]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_o = st_q.word[0];

endmodule

// File: rtl/serpar_cell.sv
module serpar_cell
    import serpar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic clear,
    input  logic a_bit,
    input  logic b_bit,
    input  logic sum_in,
    output logic sum_o,
    output logic carry_o
);
    cell_state_t st_d;
    cell_state_t st_q;
    logic        pp;
    logic [1:0]  add_r;

    always_comb begin
        pp    = a_bit & b_bit;
        add_r = fa3(pp, sum_in, st_q.carry);
        st_d  = st_q;
        if (clk_en) begin
            if (clear) begin
                st_d = '0;
            end else begin
                st_d.sum   = add_r[0];
                st_d.carry = add_r[1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_o   = st_q.sum;
    assign carry_o = st_q.carry;

endmodule

// File: rtl/serpar_array.sv
module serpar_array #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clk_en,
    input  logic         clear,
    input  logic [W-1:0] a_word,
    input  logic         b_bit,
    output logic         lsb_o
);
    logic [W:0]   sum_chain;
    logic [W-1:0] carry_unused;

    assign sum_chain[W] = 1'b0;

    generate
        for (genvar j = 0; j < W; j++) begin : g_cell
            serpar_cell u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .clk_en  (clk_en),
                .clear   (clear),
                .a_bit   (a_word[j]),
                .b_bit   (b_bit),
                .sum_in  (sum_chain[j+1]),
                .sum_o   (sum_chain[j]),
                .carry_o (carry_unused[j])
            );
        end
    endgenerate

    assign lsb_o = sum_chain[0];

endmodule

// File: rtl/serpar_sequencer.sv
module serpar_sequencer
    import serpar_pkg::*;
#(
    parameter int W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic load,
    output logic vld_o
);
    localparam int PW = 2 * W;
    localparam int CW = $clog2(PW + 1);

    typedef struct packed {
        seq_mode_t     mode;
        logic [CW-1:0] cnt;
        logic          vld;
    } seq_state_t;

    seq_state_t st_d;
    seq_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (clk_en) begin
            if (load) begin
                st_d.mode = SEQ_RUN;
                st_d.cnt  = '0;
                st_d.vld  = 1'b0;
            end else if (st_q.mode == SEQ_RUN && st_q.cnt < CW'(PW)) begin
                st_d.cnt = st_q.cnt + 1'b1;
                st_d.vld = 1'b1;
            end else begin
                st_d.mode = SEQ_IDLE;
                st_d.vld  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: SEQ_IDLE, cnt: '0, vld: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o = st_q.vld;

endmodule

// File: rtl/serpar_mult.sv
module serpar_mult #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clk_en,
    input  logic         shift_mode,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic         prod_bit,
    output logic         prod_vld
);
    typedef struct packed {
        logic [W-1:0] a_word;
    } top_state_t;

    top_state_t st_d;
    top_state_t st_q;
    logic       load;
    logic       clear;
    logic       ser_bit;
    logic       lsb;
    logic       vld;

    assign load  = ~shift_mode;
    assign clear = load;

    always_comb begin
        st_d = st_q;
        if (clk_en && load) begin
            st_d.a_word = opnd_a;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    serpar_serializer #(.W(W)) u_ser (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_en (clk_en),
        .load   (load),
        .din    (opnd_b),
        .bit_o  (ser_bit)
    );

    serpar_array #(.W(W)) u_arr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_en (clk_en),
        .clear  (clear),
        .a_word (st_q.a_word),
        .b_bit  (ser_bit),
        .lsb_o  (lsb)
    );

    serpar_sequencer #(.W(W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_en (clk_en),
        .load   (load),
        .vld_o  (vld)
    );

    assign prod_bit = lsb & vld;
    assign prod_vld = vld;

endmodule

// File: rtl/serpar_mult_checker.sv
module serpar_mult_checker #(
    parameter int W = 16
) (
    input logic clk,
    input logic rst_n,
    input logic clk_en,
    input logic shift_mode,
    input logic prod_bit,
    input logic prod_vld
);
    localparam int PW = 2 * W;
    localparam int CW = $clog2(PW + 2);

    logic [CW-1:0] shifts_q;
    logic          loaded_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shifts_q <= '0;
            loaded_q <= 1'b0;
        end else if (clk_en) begin
            if (!shift_mode) begin
                shifts_q <= '0;
                loaded_q <= 1'b1;
            end else if (shifts_q <= CW'(PW)) begin
                shifts_q <= shifts_q + 1'b1;
            end
        end
    end

    // R2: load leaves the output idle
    assert_load_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !shift_mode) |=> (!prod_vld && !prod_bit));

    // R5: a disabled edge holds the outputs
    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(prod_bit) && $stable(prod_vld)));

    // R3: valid for exactly the shifts 1..2W after a load
    assert_vld_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded_q && shifts_q >= CW'(1) && shifts_q <= CW'(PW)) |-> prod_vld);

    // R4: no valid outside that window
    assert_no_extra_vld_R4: assert property (@(posedge clk) disable iff (!rst_n)
        prod_vld |-> (loaded_q && shifts_q >= CW'(1) && shifts_q <= CW'(PW)));

    // R1: the data bit is quiet when not valid
    assert_bit_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !prod_vld |-> !prod_bit);

endmodule

bind serpar_mult serpar_mult_checker #(.W(W)) u_serpar_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .shift_mode (shift_mode),
    .prod_bit   (prod_bit),
    .prod_vld   (prod_vld)
);

// File: tb/test_serpar_mult.sv
module test_serpar_mult;
    localparam int W  = 16;
    localparam int PW = 2 * W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic         clk_en = 1'b0;
    logic         shift_mode = 1'b1;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic         prod_bit;
    logic         prod_vld;

    logic         ce4 = 1'b0;
    logic         sm4 = 1'b1;
    logic [3:0]   a4 = '0;
    logic [3:0]   b4 = '0;
    logic         bit4;
    logic         vld4;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;

    serpar_mult #(.W(W)) i_serpar_mult (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .shift_mode(shift_mode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .prod_bit(prod_bit), .prod_vld(prod_vld)
    );

    serpar_mult #(.W(4)) i_serpar_mult_w4 (
        .clk(clk), .rst_n(rst_n), .clk_en(ce4), .shift_mode(sm4),
        .opnd_a(a4), .opnd_b(b4), .prod_bit(bit4), .prod_vld(vld4)
    );

    function automatic logic [63:0] ref_mul(input logic [W-1:0] x, input logic [W-1:0] y);
        logic [63:0] r;
        r = 64'(x) * 64'(y);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic ce, input logic sm);
        clk_en     = ce;
        shift_mode = sm;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tick4(input logic ce, input logic sm);
        ce4 = ce;
        sm4 = sm;
        @(posedge clk);
        @(negedge clk);
    endtask

    // R3 R5 R8: full stream with optional stalls and operand scrambling
    task automatic run_stream(input logic [W-1:0] a, input logic [W-1:0] b,
                              input int stall_pct, input bit scramble);
        logic [PW-1:0] got;
        logic [63:0]   exp;
        logic          hb;
        logic          hv;
        bit            vld_ok;
        got    = '0;
        vld_ok = 1'b1;
        exp    = ref_mul(a, b);
        opnd_a = a;
        opnd_b = b;
        tick(1'b1, 1'b0);
        check(!prod_vld && !prod_bit, "R2 load idle", {62'd0, prod_vld, prod_bit}, 64'd0);
        for (int k = 0; k < PW; k++) begin
            if (($urandom % 100) < stall_pct) begin
                hb = prod_bit;
                hv = prod_vld;
                tick(1'b0, ($urandom % 2) == 0);
                check(prod_bit == hb && prod_vld == hv, "R5 stall hold",
                      {62'd0, prod_vld, prod_bit}, {62'd0, hv, hb});
            end
            if (scramble) begin
                opnd_a = W'($urandom);
                opnd_b = W'($urandom);
            end
            tick(1'b1, 1'b1);
            if (!prod_vld) vld_ok = 1'b0;
            got[k] = prod_bit;
        end
        check(vld_ok, "R3 valid strobe", {63'd0, vld_ok}, 64'd1);
        check(64'(got) == exp, scramble ? "R8 product under input change" : "R3 product",
              64'(got), exp);
        tick(1'b1, 1'b1);
        check(!prod_vld && !prod_bit, "R4 after stream", {62'd0, prod_vld, prod_bit}, 64'd0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_err++;
                n_chk++;
                $display("FAIL R3 watchdog actual=%0d expected=<150000", cycles);
                $display("Result: errors=%0d of %0d checks", n_err, n_chk);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!prod_vld && !prod_bit, "R1 in reset", {62'd0, prod_vld, prod_bit}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!prod_vld && !prod_bit, "R1 after reset", {62'd0, prod_vld, prod_bit}, 64'd0);

        // R4: shifting with no load since reset
        for (int i = 0; i < 5; i++) begin
            tick(1'b1, 1'b1);
            check(!prod_vld && !prod_bit, "R4 shift without load", {62'd0, prod_vld, prod_bit}, 64'd0);
        end

        // R3: directed corners
        run_stream('0, 16'hFFFF, 0, 1'b0);
        run_stream(16'hFFFF, 16'hFFFF, 0, 1'b0);
        run_stream(16'h0001, 16'hFFFF, 0, 1'b0);
        run_stream(16'hFFFF, 16'h0001, 0, 1'b0);
        run_stream(16'hAAAA, 16'h5555, 0, 1'b0);
        run_stream(16'h8000, 16'h8000, 0, 1'b0);

        // R4: further shifts after a finished stream
        for (int i = 0; i < 4; i++) begin
            tick(1'b1, 1'b1);
            check(!prod_vld && !prod_bit, "R4 idle after stream", {62'd0, prod_vld, prod_bit}, 64'd0);
        end

        // R5: stalls with random operands
        for (int i = 0; i < 30; i++) begin
            run_stream(W'($urandom), W'($urandom), 30, 1'b0);
        end

        // R8: operand ports change during the stream
        for (int i = 0; i < 15; i++) begin
            run_stream(W'($urandom), W'($urandom), 10, 1'b1);
        end

        // R6: reload in the middle of a stream
        for (int i = 0; i < 15; i++) begin
            opnd_a = 16'hFFFF;
            opnd_b = 16'hFFFF;
            tick(1'b1, 1'b0);
            for (int k = 0; k < 1 + int'($urandom % (PW - 1)); k++) tick(1'b1, 1'b1);
            begin
                logic [W-1:0] na;
                logic [W-1:0] nb;
                logic [PW-1:0] got;
                na = W'($urandom);
                nb = W'($urandom);
                if (i == 0) begin
                    na = 16'h0001;
                    nb = 16'h0001;
                end
                opnd_a = na;
                opnd_b = nb;
                tick(1'b1, 1'b0);
                for (int k = 0; k < PW; k++) begin
                    tick(1'b1, 1'b1);
                    got[k] = prod_bit;
                end
                check(64'(got) == ref_mul(na, nb), "R6 reload mid-stream", 64'(got), ref_mul(na, nb));
            end
        end

        // R7: 4-bit instance, directed example then exhaustive
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                logic [7:0] got4;
                int ex;
                ex = (x == 0 && y == 0) ? 30 : x * y;
                a4 = (x == 0 && y == 0) ? 4'b0011 : 4'(x);
                b4 = (x == 0 && y == 0) ? 4'b1010 : 4'(y);
                tick4(1'b1, 1'b0);
                for (int k = 0; k < 8; k++) begin
                    tick4(1'b1, 1'b1);
                    got4[k] = bit4;
                end
                check(32'(got4) == ex, "R7 four-bit product", 64'(got4), 64'(ex));
            end
        end
        ce4 = 1'b0;

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule